// File: doc/BRIEF.md
# Two-Channel Timer Capture/Compare Unit

Two timer channels are built around one free-running counter. Each channel has a control/status register and a value register. A channel can time-stamp edges on its pin (input capture) or act on its pin when the counter reaches a programmed value (output compare). Each channel raises an event flag, which reaches that channel's interrupt output when enabled.

Software clears a flag with a two-step handshake. It first reads the control register while the flag shows 1, then writes 0 to the flag bit. An event that lands between the read and the write keeps the flag set, so no event is lost.

Channel 0 also has a buffered compare mode. In this mode it compares against a double-buffered value fed from both value registers, and it swaps in the newest value only when the counter wraps. While that mode is on, channel 1 is switched off and its pin is handed back to general-purpose use.

Top module: `tcc_unit`

## Requirements
- R1: Register map on the bus: address 0 is the channel 0 control register, 1 is the channel 0 value, 2 is the channel 1 control register, 3 is the channel 1 value, and 4 reads the counter. Control register bits: 7 is the flag, 6 is the interrupt enable, 5 is the buffered-mode select (channel 0 only), 4 is mode bit A, and 3:2 is the edge/action select. All other bits read 0.
- R2: In capture mode (mode A = 0, select nonzero), select 01 reacts to rising edges, 10 to falling edges and 11 to both. A pin level first sampled at clock k sets the flag at clock k+2. On that same clock the value register loads the counter value present at that clock.
- R3: The flag clears only on a write of 0 to bit 7 that follows a read strobe of the control register taken while the flag was 1. A write with no such earlier read leaves the flag set.
- R4: An event that arrives after the arming read and before the clearing write keeps the flag set, and the write of 0 is ignored. An event always wins over a write in the same clock.
- R5: Writing 1 to the flag bit has no effect. Reset clears the flag, all control bits, the value registers and the counter.
- R6: A channel's interrupt output is high exactly while its flag and its interrupt enable are both 1.
- R7: While bit 5 of the channel 0 control register is 1, channel 1's control register reads 0 and ignores writes. Channel 1 cannot raise its flag, its interrupt output stays low, and its pin output enable is 0.
- R8: In buffered mode, channel 0 compares against an active value. When the counter wraps from all-ones to zero, that active value reloads from whichever value register (address 1 or 3) was written most recently. It does not change at any other time.
- R9: In compare mode (mode A = 1, or buffered mode on channel 0, with select nonzero), a match between the counter and the compare value sets the flag. On the same clock the pin output changes as follows: select 01 toggles it, 10 drives it to 0, 11 drives it to 1.
- R10: The pin output enable is 1 only in compare mode. When the select is 00, or in capture mode, the pin is released to general-purpose use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe (arms the flag clear) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr (combinational) |
| pin_in | input | 2 | Channel pin input levels |
| pin_out | output | 2 | Channel pin drive values |
| pin_oe | output | 2 | Channel pin output enables (0 = general-purpose) |
| irq | output | 2 | Per-channel interrupt requests |

## Verification
The assertions assume that a flag can only drop through a bus write, and that each bus strobe lasts one clock. The stimulus drives exactly one of read or write at a time, changing it between clock edges. The assertions also assume the pin inputs are quiet during reset, so no false edge is seen when reset releases; the bench holds both pins low through reset. Pin changes are spaced at least four clocks apart, so every level passes through the synchronizer before the next change, and the edge-select cases give one event per change.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
   // register addresses
   localparam int unsigned A_CH0_CTL = 0;
   localparam int unsigned A_CH0_VAL = 1;
   localparam int unsigned A_CH1_CTL = 2;
   localparam int unsigned A_CH1_VAL = 3;
   localparam int unsigned A_COUNT   = 4;

   // control register bit positions
   localparam int unsigned B_FLAG   = 7;
   localparam int unsigned B_IE     = 6;
   localparam int unsigned B_BUF    = 5;
   localparam int unsigned B_MODE   = 4;
   localparam int unsigned B_SEL_HI = 3;
   localparam int unsigned B_SEL_LO = 2;

   // edge/action select: capture edge in capture mode, pin action in compare mode
   typedef enum logic [1:0] {
      SEL_OFF      = 2'b00,
      SEL_RISE_TGL = 2'b01,
      SEL_FALL_CLR = 2'b10,
      SEL_BOTH_SET = 2'b11
   } sel_e;

   typedef struct packed {
      logic ie;
      logic mode_a;
      sel_e sel;
   } ctl_t;
endpackage

// File: rtl/tcc_counter.sv
module tcc_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   // asserted during the clock whose edge rolls the count over to zero
   assign wrap = &cnt;
endmodule

// File: rtl/tcc_edge_sync.sv
module tcc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] shr;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shr  <= '0;
         last <= 1'b0;
      end else begin
         shr  <= {shr[STAGES-2:0], din};
         last <= shr[STAGES-1];
      end
   end

   assign rise = shr[STAGES-1] & ~last;
   assign fall = ~shr[STAGES-1] & last;
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
   import tcc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter bit HAS_BUF     = 1'b0,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [CNT_W-1:0] wdata,
   input  logic             dis,
   input  logic             wr_ctl,
   input  logic             rd_ctl,
   input  logic             wr_val,
   input  logic             pin_in,
   output logic [7:0]       ctl_rd,
   output logic [CNT_W-1:0] val,
   output logic             pin_out,
   output logic             pin_oe,
   output logic             irq,
   output logic             bufm,
   output logic             evt,
   output logic             flag
);
   ctl_t             ctl_q;
   logic             flag_q;
   logic             arm_q;
   logic             pin_q;
   logic [CNT_W-1:0] val_q;
   logic             rise;
   logic             fall;
   logic             on;
   logic             is_cmp;
   logic             is_cap;
   logic             cap_hit;
   logic             cmp_hit;
   logic             wr_c;
   logic             rd_c;
   logic             clr_req;

   tcc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_in),
      .rise (rise),
      .fall (fall)
   );

   // buffered-mode select exists only where the parameter asks for it
   generate
      if (HAS_BUF) begin : g_buf
         logic buf_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    buf_q <= 1'b0;
            else if (wr_c) buf_q <= wdata[B_BUF];
         end
         assign bufm = buf_q;
      end else begin : g_nobuf
         assign bufm = 1'b0;
      end
   endgenerate

   assign wr_c    = wr_ctl & ~dis;
   assign rd_c    = rd_ctl & ~dis;
   assign on      = ~dis & (ctl_q.sel != SEL_OFF);
   assign is_cmp  = on & (ctl_q.mode_a | bufm);
   assign is_cap  = on & ~is_cmp;
   assign cap_hit = is_cap & ((ctl_q.sel[0] & rise) | (ctl_q.sel[1] & fall));
   assign cmp_hit = is_cmp & (cnt == cmp_val);
   assign evt     = cap_hit | cmp_hit;
   assign clr_req = wr_c & ~wdata[B_FLAG] & arm_q;

   // flag and arming latch: an event always dominates the clearing write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         if (evt)          flag_q <= 1'b1;
         else if (clr_req) flag_q <= 1'b0;

         if (evt || wr_c)        arm_q <= 1'b0;
         else if (rd_c && flag_q) arm_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '{ie: 1'b0, mode_a: 1'b0, sel: SEL_OFF};
      end else if (wr_c) begin
         ctl_q.ie     <= wdata[B_IE];
         ctl_q.mode_a <= wdata[B_MODE];
         ctl_q.sel    <= sel_e'(wdata[B_SEL_HI:B_SEL_LO]);
      end
   end

   // value register: a capture outranks a bus write in the same clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       val_q <= '0;
      else if (cap_hit) val_q <= cnt;
      else if (wr_val)  val_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
      end else if (cmp_hit) begin
         unique case (ctl_q.sel)
            SEL_RISE_TGL: pin_q <= ~pin_q;
            SEL_FALL_CLR: pin_q <= 1'b0;
            SEL_BOTH_SET: pin_q <= 1'b1;
            default:      pin_q <= pin_q;
         endcase
      end
   end

   assign ctl_rd  = dis ? 8'h00
                        : {flag_q, ctl_q.ie, bufm, ctl_q.mode_a, ctl_q.sel, 2'b00};
   assign val     = val_q;
   assign pin_out = pin_q;
   assign pin_oe  = is_cmp;
   assign irq     = flag_q & ctl_q.ie & ~dis;
   assign flag    = flag_q;
endmodule

// File: rtl/tcc_unit.sv
module tcc_unit
   import tcc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic [1:0]        pin_in,
   output logic [1:0]        pin_out,
   output logic [1:0]        pin_oe,
   output logic [1:0]        irq
);
   localparam int NCH = 2;

   generate
      if (CNT_W < 8) begin : g_chk_w
         $error("tcc_unit: CNT_W must hold the 8-bit control register");
      end
      if (ADDR_W < 3) begin : g_chk_a
         $error("tcc_unit: ADDR_W must reach the counter address");
      end
      if (SYNC_STAGES < 2) begin : g_chk_s
         $error("tcc_unit: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             wrap;
   logic [NCH-1:0]   sel_ctl;
   logic [NCH-1:0]   sel_val;
   logic [NCH-1:0]   flag_v;
   logic [NCH-1:0]   evt_v;
   logic [NCH-1:0]   bufm_v;
   logic [CNT_W-1:0] val_a [NCH];
   logic [CNT_W-1:0] cmp_a [NCH];
   logic [7:0]       ctl_a [NCH];
   logic             buf_mode;
   logic             last_sel;
   logic [CNT_W-1:0] act_cmp;

   tcc_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .cnt  (cnt),
      .wrap (wrap)
   );

   // only channel 0 can hold the buffered bit; channel 1 ties it low
   assign buf_mode = |bufm_v;

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_ch
         assign sel_ctl[g] = (bus_addr == ADDR_W'(2 * g));
         assign sel_val[g] = (bus_addr == ADDR_W'(2 * g + 1));

         if (g == 0) begin : g_cmp_buf
            assign cmp_a[g] = buf_mode ? act_cmp : val_a[g];
         end else begin : g_cmp_own
            assign cmp_a[g] = val_a[g];
         end

         tcc_channel #(
            .CNT_W      (CNT_W),
            .HAS_BUF    (g == 0),
            .SYNC_STAGES(SYNC_STAGES)
         ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt    (cnt),
            .cmp_val(cmp_a[g]),
            .wdata  (bus_wdata),
            .dis    ((g != 0) && buf_mode),
            .wr_ctl (bus_wr & sel_ctl[g]),
            .rd_ctl (bus_rd & sel_ctl[g]),
            .wr_val (bus_wr & sel_val[g]),
            .pin_in (pin_in[g]),
            .ctl_rd (ctl_a[g]),
            .val    (val_a[g]),
            .pin_out(pin_out[g]),
            .pin_oe (pin_oe[g]),
            .irq    (irq[g]),
            .bufm   (bufm_v[g]),
            .evt    (evt_v[g]),
            .flag   (flag_v[g])
         );
      end
   endgenerate

   // double buffer for channel 0: remember the newest write, load it on wrap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_sel <= 1'b0;
         act_cmp  <= '0;
      end else begin
         if (bus_wr && sel_val[0])      last_sel <= 1'b0;
         else if (bus_wr && sel_val[1]) last_sel <= 1'b1;
         if (wrap) act_cmp <= last_sel ? val_a[1] : val_a[0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(A_COUNT)) bus_rdata = cnt;
      for (int k = 0; k < NCH; k++) begin
         if (sel_ctl[k]) bus_rdata = CNT_W'(ctl_a[k]);
         if (sel_val[k]) bus_rdata = val_a[k];
      end
   end
endmodule

// File: rtl/tcc_unit_chk.sv
module tcc_unit_chk
   import tcc_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [CNT_W-1:0]  bus_wdata,
   input logic [1:0]        irq,
   input logic [1:0]        pin_oe,
   input logic [1:0]        flag_v,
   input logic [1:0]        evt_v,
   input logic              buf_mode,
   input logic [CNT_W-1:0]  act_cmp,
   input logic              wrap
);
   a_r3_ch0_drop_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_v[0]) |-> $past(bus_wr && bus_addr == ADDR_W'(A_CH0_CTL) && !bus_wdata[B_FLAG]));

   a_r3_ch1_drop_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_v[1]) |-> $past(bus_wr && bus_addr == ADDR_W'(A_CH1_CTL) && !bus_wdata[B_FLAG]));

   a_r4_ch0_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt_v[0] |=> flag_v[0]);

   a_r4_ch1_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt_v[1] |=> flag_v[1]);

   a_r6_irq_needs_flag0: assert property (@(posedge clk) disable iff (!rst_n)
      irq[0] |-> flag_v[0]);

   a_r6_irq_needs_flag1: assert property (@(posedge clk) disable iff (!rst_n)
      irq[1] |-> flag_v[1]);

   a_r7_ch1_silent: assert property (@(posedge clk) disable iff (!rst_n)
      buf_mode |-> (!irq[1] && !pin_oe[1] && !evt_v[1]));

   a_r8_swap_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_cmp) |-> $past(wrap));
endmodule

bind tcc_unit tcc_unit_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .irq      (irq),
   .pin_oe   (pin_oe),
   .flag_v   (flag_v),
   .evt_v    (evt_v),
   .buf_mode (buf_mode),
   .act_cmp  (act_cmp),
   .wrap     (wrap)
);

// File: tb/tcc_unit_tb.sv
module tcc_unit_tb;
   localparam int CW = 10;
   localparam int AW = 3;
   localparam int MOD = 1 << CW;

   // compare-action vectors: {select[1:0], expected pin after match}
   localparam logic [2:0] VEC [6] = '{3'b111, 3'b010, 3'b011, 3'b100, 3'b111, 3'b100};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          rd = 1'b0;
   logic          wr = 1'b0;
   logic [CW-1:0] wdata = '0;
   logic [CW-1:0] rdata;
   logic [1:0]    pin_in = 2'b00;
   logic [1:0]    pin_out;
   logic [1:0]    pin_oe;
   logic [1:0]    irq;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   tcc_unit #(.CNT_W(CW), .ADDR_W(AW)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (addr),
      .bus_rd   (rd),
      .bus_wr   (wr),
      .bus_wdata(wdata),
      .bus_rdata(rdata),
      .pin_in   (pin_in),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe),
      .irq      (irq)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic peek(input int a, output int v);
      addr = AW'(a);
      #1;
      v = int'(rdata);
   endtask

   task automatic wr_reg(input int a, input int d);
      addr  = AW'(a);
      wdata = CW'(d);
      wr    = 1'b1;
      @(negedge clk);
      wr    = 1'b0;
   endtask

   task automatic rd_pulse(input int a);
      addr = AW'(a);
      rd   = 1'b1;
      @(negedge clk);
      rd   = 1'b0;
   endtask

   task automatic flag_of(input int a, output int f);
      int v;
      peek(a, v);
      f = (v >> 7) & 1;
   endtask

   task automatic wait_cnt(input int target);
      int v;
      for (int i = 0; i < 3 * MOD; i++) begin
         peek(4, v);
         if (v == target) return;
         @(negedge clk);
      end
      check("R8", "counter never reached target", v, target);
   endtask

   initial begin
      #(20 * 150000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      int v;
      int f;
      int c;
      int prev_pin;

      // ---------------- reset state (R5, R10)
      tick(3);
      peek(4, v); check("R5", "counter in reset", v, 0);
      peek(0, v); check("R5", "ch0 ctl in reset", v, 0);
      peek(2, v); check("R5", "ch1 ctl in reset", v, 0);
      check("R6", "irq in reset", int'(irq), 0);
      check("R10", "oe in reset", int'(pin_oe), 0);
      rst_n = 1'b1;
      tick(2);

      // ---------------- compare action table on channel 0 (R9, R3, R1)
      prev_pin = 0;
      foreach (VEC[j]) begin
         int ctl;
         ctl = 'h10 | (int'(VEC[j][2:1]) << 2);
         wr_reg(0, ctl);
         peek(4, c);
         wr_reg(1, (c + 8) % MOD);
         tick(4);
         flag_of(0, f); check("R9", "flag before match", f, 0);
         check("R9", "pin before match", int'(pin_out[0]), prev_pin);
         tick(5);
         flag_of(0, f); check("R9", "flag after match", f, 1);
         check("R9", "pin after match", int'(pin_out[0]), int'(VEC[j][0]));
         check("R10", "oe in compare", int'(pin_oe[0]), 1);
         rd_pulse(0);
         wr_reg(0, ctl);
         flag_of(0, f); check("R3", "flag after read+write0", f, 0);
         prev_pin = int'(VEC[j][0]);
      end
      wr_reg(0, 0);
      check("R10", "oe released with select 00", int'(pin_oe[0]), 0);

      // ---------------- capture on channel 1 (R2, R10)
      wr_reg(2, 'h04);
      check("R10", "oe in capture", int'(pin_oe[1]), 0);
      peek(4, c);
      pin_in[1] = 1'b1;
      tick(2);
      flag_of(2, f); check("R2", "flag one clock early", f, 0);
      tick(1);
      flag_of(2, f); check("R2", "rising edge flag", f, 1);
      peek(3, v); check("R2", "captured count", v, (c + 2) % MOD);
      rd_pulse(2); wr_reg(2, 'h04);
      pin_in[1] = 1'b0;
      tick(4);
      flag_of(2, f); check("R2", "falling ignored in rising mode", f, 0);
      wr_reg(2, 'h08);
      pin_in[1] = 1'b1;
      tick(4);
      flag_of(2, f); check("R2", "rising ignored in falling mode", f, 0);
      pin_in[1] = 1'b0;
      tick(4);
      flag_of(2, f); check("R2", "falling edge flag", f, 1);
      rd_pulse(2); wr_reg(2, 'h0C);
      pin_in[1] = 1'b1;
      tick(4);
      flag_of(2, f); check("R2", "both-edge mode on rise", f, 1);

      // ---------------- clear race and handshake (R4, R3, R5)
      rd_pulse(2);
      pin_in[1] = 1'b0;
      tick(4);
      wr_reg(2, 'h0C);
      flag_of(2, f); check("R4", "event between read and write keeps flag", f, 1);
      wr_reg(2, 'h0C);
      flag_of(2, f); check("R3", "write without arming read keeps flag", f, 1);
      rd_pulse(2); wr_reg(2, 'h0C);
      flag_of(2, f); check("R3", "read then write0 clears", f, 0);
      wr_reg(2, 'h8C);
      flag_of(2, f); check("R5", "write of 1 does not set flag", f, 0);
      peek(2, v); check("R1", "ch1 ctl readback", v, 'h0C);

      // ---------------- interrupt gating (R6)
      wr_reg(2, 'h4C);
      pin_in[1] = 1'b1;
      tick(4);
      check("R6", "irq with enable and flag", int'(irq[1]), 1);
      wr_reg(2, 'h0C);
      check("R6", "irq gated by enable", int'(irq[1]), 0);
      flag_of(2, f); check("R6", "flag held while irq gated", f, 1);
      rd_pulse(2); wr_reg(2, 'h0C);

      // ---------------- buffered mode (R7, R8)
      wr_reg(0, 'h34);
      peek(2, v); check("R7", "ch1 ctl reads 0", v, 0);
      check("R7", "ch1 oe off", int'(pin_oe[1]), 0);
      wr_reg(2, 'h4C);
      pin_in[1] = 1'b0;
      tick(4);
      check("R7", "ch1 irq quiet", int'(irq[1]), 0);
      wr_reg(1, 100);
      wr_reg(3, 300);
      wait_cnt(MOD - 4);
      wait_cnt(5);
      rd_pulse(0); wr_reg(0, 'h34);
      wait_cnt(200);
      flag_of(0, f); check("R8", "older buffer value not active", f, 0);
      wait_cnt(320);
      flag_of(0, f); check("R8", "newest buffer value active", f, 1);
      wr_reg(1, 500);
      rd_pulse(0); wr_reg(0, 'h34);
      wait_cnt(600);
      flag_of(0, f); check("R8", "no mid-period swap", f, 0);
      wait_cnt(MOD - 4);
      wait_cnt(400);
      flag_of(0, f); check("R8", "old value dropped after wrap", f, 0);
      wait_cnt(520);
      flag_of(0, f); check("R8", "new value after wrap", f, 1);
      wr_reg(0, 'h00);
      peek(2, v); check("R7", "ch1 ctl write ignored in buffered mode", v, 'h0C);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule